// File: doc/BRIEF.md
# Adapter Command and Status Port

This block is the host side of a network adapter controller's control path. The host writes a 16-bit command word to one port. The top five bits of that word are an opcode and the low eleven bits are an argument. The host reads back a 16-bit status word from the same place. The block decodes each command and updates its state: the selected register window, the receive and transmit enables, the statistics and transceiver enables, the receive filter, three threshold values, an interrupt enable mask and a read-visibility mask.

The status word carries seven sticky event bits and an interrupt latch bit, which drives the interrupt line. The event bits are set by pulses from the surrounding controller logic or by a host request, and the host clears them with an acknowledge command that takes a bit mask.

Four commands take more than one cycle: global reset, transceiver start, receive reset and transmit reset. For each of these the block raises a busy flag and reports which operation is pending. It then waits for a done pulse from the logic that carries out the operation, and it ignores every command that arrives in the meantime.

Top module: `cmdstat_port`

## Requirements
- R1: A command word is accepted when `cmdWr` is high and the block is not busy. Its opcode is bits 15..11 and its argument is bits 10..0. Opcode 1 loads the window number from argument bits 2..0 and ignores the other argument bits. The window appears on `windowSel` and on status bits 15..13 one cycle after the write.
- R2: Opcode 13 is an acknowledge. Each argument bit n in 7..0 that is set clears status bit n. If an event pulse for a bit arrives in the same cycle as its acknowledge, the bit stays set.
- R3: Status bits 7..1 are, from bit 1 upward: adapter failure, TX complete, TX available, RX complete, RX early, interrupt requested, statistics update. Each bit is set one cycle after a pulse on the matching `evtPulse` bit and then stays set. Opcode 12 sets bit 6 in the same way.
- R4: Status bit 0, the interrupt latch, is set one cycle after a cycle in which any event source for bits 7..1 is active while its interrupt-mask bit is 1. The latch holds until an acknowledge with argument bit 0 set. `irq` is the latch value.
- R5: Opcode 14 loads the interrupt mask from argument bits 7..0. Opcode 15 loads the read mask from argument bits 7..0. A status bit in 7..0 whose read-mask bit is 0 reads as zero but stays latched, so it reappears when the mask bit is set again.
- R6: Status bits 11..8 always read as zero. Status bit 12 equals `cmdBusy`.
- R7: After reset the receiver and transmitter are disabled. Opcodes 4 and 3 enable and disable receive. Opcodes 9 and 10 enable and disable transmit.
- R8: Opcode 16 loads `rxFilter` from argument bits 3..0: bit 0 own address, bit 1 multicast, bit 2 broadcast, bit 3 all frames. Opcodes 17, 18 and 19 load `rxEarlyThresh`, `txAvailThresh` and `txStartThresh` from the full 11-bit argument.
- R9: Opcodes 0, 2, 5 and 11 raise `cmdBusy` one cycle after acceptance. `longOp` is set to 0, 1, 2 or 3 respectively. `cmdBusy` stays high until a cycle with `opDone` high and drops one cycle later. Commands written while busy have no effect, and `opDone` while idle has no effect.
- R10: Opcode 0 returns every register to its reset value in the cycle after acceptance: window 0, all enables off, filter and thresholds 0, event bits and latch clear, interrupt mask 0, read mask all ones. Events arriving in the same cycle are dropped.
- R11: Opcode 5 also disables the receiver and opcode 11 also disables the transmitter. Opcode 2 sets `xcvrEnable` and opcode 23 clears it. Opcodes 21 and 22 set and clear `statsEnable`.
- R12: Opcodes 6, 7, 8, 20 and 24 to 31 change no output and no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWr | input | 1 | Command write strobe |
| cmdData | input | 16 | Command word: opcode in bits 15..11, argument in bits 10..0 |
| evtPulse | input | 7 | Event pulses for status bits 7..1 |
| opDone | input | 1 | Completion pulse for a pending multi-cycle operation |
| statusWord | output | 16 | Window, busy flag and the masked event and latch bits |
| windowSel | output | 3 | Currently selected register window |
| irq | output | 1 | Interrupt line, equal to the latch |
| cmdBusy | output | 1 | Multi-cycle command in progress |
| longOp | output | 2 | Pending operation: 0 reset, 1 transceiver start, 2 RX reset, 3 TX reset |
| rxEnable | output | 1 | Receiver enabled |
| txEnable | output | 1 | Transmitter enabled |
| statsEnable | output | 1 | Statistics enabled |
| xcvrEnable | output | 1 | Transceiver running |
| rxFilter | output | 4 | Receive filter bits |
| rxEarlyThresh | output | 11 | RX early threshold |
| txAvailThresh | output | 11 | TX available threshold |
| txStartThresh | output | 11 | TX start threshold |

## Verification
The assertions assume that `opDone` is meaningful only while a multi-cycle command is pending. They also assume that event pulses may arrive in any cycle, including cycles that carry a command. The stimulus therefore pulses `opDone` mostly while busy, and sometimes while idle to exercise R9. Random event pulses overlap acknowledges, global resets and request commands, so the ordering rules for those collisions are exercised.

// File: rtl/cmdstat_pkg.sv
package cmdstat_pkg;
  localparam int WORD_W = 16;
  localparam int OP_W   = 5;
  localparam int ARG_W  = WORD_W - OP_W;
  localparam int WIN_W  = 3;
  localparam int EVT_W  = 8;
  localparam int FIL_W  = 4;
  localparam int THR_W  = ARG_W;
  localparam int LOP_W  = 2;
  localparam int REQ_BIT = 6;

  typedef enum logic [OP_W-1:0] {
    OP_GRESET    = 5'd0,
    OP_WINSEL    = 5'd1,
    OP_XCVR_UP   = 5'd2,
    OP_RX_OFF    = 5'd3,
    OP_RX_ON     = 5'd4,
    OP_RX_RST    = 5'd5,
    OP_TX_ON     = 5'd9,
    OP_TX_OFF    = 5'd10,
    OP_TX_RST    = 5'd11,
    OP_REQ_INT   = 5'd12,
    OP_ACK       = 5'd13,
    OP_INT_MASK  = 5'd14,
    OP_RD_MASK   = 5'd15,
    OP_FILTER    = 5'd16,
    OP_RX_EARLY  = 5'd17,
    OP_TX_AVAIL  = 5'd18,
    OP_TX_START  = 5'd19,
    OP_STATS_ON  = 5'd21,
    OP_STATS_OFF = 5'd22,
    OP_XCVR_DN   = 5'd23
  } opcode_e;

  typedef enum logic [LOP_W-1:0] {
    LOP_GRESET = 2'd0,
    LOP_XCVR   = 2'd1,
    LOP_RXRST  = 2'd2,
    LOP_TXRST  = 2'd3
  } longop_e;

  typedef struct packed {
    logic gReset;
    logic winSel;
    logic ack;
    logic reqInt;
    logic ldIntMask;
    logic ldRdMask;
    logic ldFilter;
    logic ldRxEarly;
    logic ldTxAvail;
    logic ldTxStart;
    logic rxOn;
    logic rxOff;
    logic txOn;
    logic txOff;
    logic statsOn;
    logic statsOff;
    logic xcvrOn;
    logic xcvrOff;
  } strobe_t;
endpackage

// File: rtl/cmdstat_ctrl.sv
module cmdstat_ctrl
  import cmdstat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic [WORD_W-1:0] cmdData,
  input  logic              opDone,
  output strobe_t           stb,
  output logic [ARG_W-1:0]  cmdArg,
  output logic              busy,
  output logic [LOP_W-1:0]  longOp
);
  logic    accept;
  logic    isLong;
  longop_e nextOp;
  opcode_e op;

  assign accept = cmdWr && !busy;
  assign op     = opcode_e'(cmdData[WORD_W-1:ARG_W]);
  assign cmdArg = cmdData[ARG_W-1:0];

  always_comb begin
    stb    = '0;
    isLong = 1'b0;
    nextOp = LOP_GRESET;
    if (accept) begin
      case (op)
        OP_GRESET:    begin stb.gReset = 1'b1; isLong = 1'b1; nextOp = LOP_GRESET; end
        OP_WINSEL:    stb.winSel = 1'b1;
        OP_XCVR_UP:   begin stb.xcvrOn = 1'b1; isLong = 1'b1; nextOp = LOP_XCVR; end
        OP_RX_OFF:    stb.rxOff = 1'b1;
        OP_RX_ON:     stb.rxOn = 1'b1;
        OP_RX_RST:    begin stb.rxOff = 1'b1; isLong = 1'b1; nextOp = LOP_RXRST; end
        OP_TX_ON:     stb.txOn = 1'b1;
        OP_TX_OFF:    stb.txOff = 1'b1;
        OP_TX_RST:    begin stb.txOff = 1'b1; isLong = 1'b1; nextOp = LOP_TXRST; end
        OP_REQ_INT:   stb.reqInt = 1'b1;
        OP_ACK:       stb.ack = 1'b1;
        OP_INT_MASK:  stb.ldIntMask = 1'b1;
        OP_RD_MASK:   stb.ldRdMask = 1'b1;
        OP_FILTER:    stb.ldFilter = 1'b1;
        OP_RX_EARLY:  stb.ldRxEarly = 1'b1;
        OP_TX_AVAIL:  stb.ldTxAvail = 1'b1;
        OP_TX_START:  stb.ldTxStart = 1'b1;
        OP_STATS_ON:  stb.statsOn = 1'b1;
        OP_STATS_OFF: stb.statsOff = 1'b1;
        OP_XCVR_DN:   stb.xcvrOff = 1'b1;
        default:      stb = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      longOp <= LOP_GRESET;
    end else if (busy && opDone) begin
      busy   <= 1'b0;
    end else if (isLong) begin
      busy   <= 1'b1;
      longOp <= nextOp;
    end
  end

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !opDone) |=> busy);

  // R9
  busy_op_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !opDone) |=> $stable(longOp));

  // R9
  busy_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && opDone) |=> !busy);
endmodule

// File: rtl/cmdstat_dp.sv
module cmdstat_dp
  import cmdstat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ARG_W-1:0]  cmdArg,
  input  logic [EVT_W-1:1]  evtPulse,
  output logic [WIN_W-1:0]  windowSel,
  output logic [EVT_W-1:0]  visibleBits,
  output logic              irq,
  output logic              rxEnable,
  output logic              txEnable,
  output logic              statsEnable,
  output logic              xcvrEnable,
  output logic [FIL_W-1:0]  rxFilter,
  output logic [THR_W-1:0]  rxEarlyThresh,
  output logic [THR_W-1:0]  txAvailThresh,
  output logic [THR_W-1:0]  txStartThresh
);
  logic [EVT_W-1:1] evtBits;
  logic             latchBit;
  logic [EVT_W-1:0] intMask;
  logic [EVT_W-1:0] rdMask;
  logic [EVT_W-1:1] evtVec;
  logic [EVT_W-1:0] ackMask;
  logic             newSet;

  always_comb begin
    evtVec          = evtPulse;
    evtVec[REQ_BIT] = evtPulse[REQ_BIT] | stb.reqInt;
  end

  assign ackMask = stb.ack ? cmdArg[EVT_W-1:0] : '0;
  assign newSet  = |(evtVec & intMask[EVT_W-1:1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      windowSel     <= '0;
      evtBits       <= '0;
      latchBit      <= 1'b0;
      intMask       <= '0;
      rdMask        <= '1;
      rxFilter      <= '0;
      rxEarlyThresh <= '0;
      txAvailThresh <= '0;
      txStartThresh <= '0;
      rxEnable      <= 1'b0;
      txEnable      <= 1'b0;
      statsEnable   <= 1'b0;
      xcvrEnable    <= 1'b0;
    end else if (stb.gReset) begin
      windowSel     <= '0;
      evtBits       <= '0;
      latchBit      <= 1'b0;
      intMask       <= '0;
      rdMask        <= '1;
      rxFilter      <= '0;
      rxEarlyThresh <= '0;
      txAvailThresh <= '0;
      txStartThresh <= '0;
      rxEnable      <= 1'b0;
      txEnable      <= 1'b0;
      statsEnable   <= 1'b0;
      xcvrEnable    <= 1'b0;
    end else begin
      evtBits  <= (evtBits & ~ackMask[EVT_W-1:1]) | evtVec;
      latchBit <= (latchBit & ~ackMask[0]) | newSet;
      if (stb.winSel)    windowSel     <= cmdArg[WIN_W-1:0];
      if (stb.ldIntMask) intMask       <= cmdArg[EVT_W-1:0];
      if (stb.ldRdMask)  rdMask        <= cmdArg[EVT_W-1:0];
      if (stb.ldFilter)  rxFilter      <= cmdArg[FIL_W-1:0];
      if (stb.ldRxEarly) rxEarlyThresh <= cmdArg;
      if (stb.ldTxAvail) txAvailThresh <= cmdArg;
      if (stb.ldTxStart) txStartThresh <= cmdArg;
      if (stb.rxOn)      rxEnable      <= 1'b1;
      if (stb.rxOff)     rxEnable      <= 1'b0;
      if (stb.txOn)      txEnable      <= 1'b1;
      if (stb.txOff)     txEnable      <= 1'b0;
      if (stb.statsOn)   statsEnable   <= 1'b1;
      if (stb.statsOff)  statsEnable   <= 1'b0;
      if (stb.xcvrOn)    xcvrEnable    <= 1'b1;
      if (stb.xcvrOff)   xcvrEnable    <= 1'b0;
    end
  end

  assign visibleBits = {evtBits, latchBit} & rdMask;
  assign irq         = latchBit;

  // R2
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && !stb.gReset) |=> ((evtBits & $past(ackMask[EVT_W-1:1] & ~evtVec)) == '0));

  // R3
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.gReset && !stb.ack) |=> ((evtBits & $past(evtBits | evtVec)) == $past(evtBits | evtVec)));

  // R4
  latch_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchBit) |-> $past(|(evtVec & intMask[EVT_W-1:1])));

  // R7
  rx_on_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxEnable) |-> $past(stb.rxOn));
endmodule

// File: rtl/cmdstat_port.sv
module cmdstat_port
  import cmdstat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic [15:0]       cmdData,
  input  logic [7:1]        evtPulse,
  input  logic              opDone,
  output logic [15:0]       statusWord,
  output logic [2:0]        windowSel,
  output logic              irq,
  output logic              cmdBusy,
  output logic [1:0]        longOp,
  output logic              rxEnable,
  output logic              txEnable,
  output logic              statsEnable,
  output logic              xcvrEnable,
  output logic [3:0]        rxFilter,
  output logic [10:0]       rxEarlyThresh,
  output logic [10:0]       txAvailThresh,
  output logic [10:0]       txStartThresh
);
  localparam int PAD_W = WORD_W - WIN_W - 1 - EVT_W;

  strobe_t          stb;
  logic [ARG_W-1:0] cmdArg;
  logic [EVT_W-1:0] visibleBits;

  cmdstat_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdWr   (cmdWr),
    .cmdData (cmdData),
    .opDone  (opDone),
    .stb     (stb),
    .cmdArg  (cmdArg),
    .busy    (cmdBusy),
    .longOp  (longOp)
  );

  cmdstat_dp uDp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .cmdArg        (cmdArg),
    .evtPulse      (evtPulse),
    .windowSel     (windowSel),
    .visibleBits   (visibleBits),
    .irq           (irq),
    .rxEnable      (rxEnable),
    .txEnable      (txEnable),
    .statsEnable   (statsEnable),
    .xcvrEnable    (xcvrEnable),
    .rxFilter      (rxFilter),
    .rxEarlyThresh (rxEarlyThresh),
    .txAvailThresh (txAvailThresh),
    .txStartThresh (txStartThresh)
  );

  assign statusWord = {windowSel, cmdBusy, {PAD_W{1'b0}}, visibleBits};

  // R1
  win_report_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !cmdBusy && cmdData[15:11] == 5'd1) |=> (statusWord[15:13] == $past(cmdData[2:0])));
endmodule

// File: tb/cmdstat_port_test.sv
module cmdstat_port_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWr = 1'b0;
  logic [15:0] cmdData = '0;
  logic [7:1]  evtPulse = '0;
  logic        opDone = 1'b0;
  logic [15:0] statusWord;
  logic [2:0]  windowSel;
  logic        irq, cmdBusy, rxEnable, txEnable, statsEnable, xcvrEnable;
  logic [1:0]  longOp;
  logic [3:0]  rxFilter;
  logic [10:0] rxEarlyThresh, txAvailThresh, txStartThresh;

  int total = 0;
  int bad = 0;
  string phase = "R7";

  // expected state
  logic [2:0]  mWin;
  logic [7:1]  mEvt;
  logic        mLatch;
  logic [7:0]  mIntMask, mRdMask;
  logic [3:0]  mFilt;
  logic [10:0] mRxE, mTxA, mTxS;
  logic        mRx, mTx, mStats, mXcvr, mBusy;
  logic [1:0]  mLop;

  always #10 clk = ~clk;

  cmdstat_port uut (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdData(cmdData), .evtPulse(evtPulse),
    .opDone(opDone), .statusWord(statusWord), .windowSel(windowSel), .irq(irq),
    .cmdBusy(cmdBusy), .longOp(longOp), .rxEnable(rxEnable), .txEnable(txEnable),
    .statsEnable(statsEnable), .xcvrEnable(xcvrEnable), .rxFilter(rxFilter),
    .rxEarlyThresh(rxEarlyThresh), .txAvailThresh(txAvailThresh), .txStartThresh(txStartThresh)
  );

  function automatic logic [15:0] word(input int op, input int arg);
    return {op[4:0], arg[10:0]};
  endfunction

  task automatic modelReset();
    mWin = '0; mEvt = '0; mLatch = 1'b0; mIntMask = '0; mRdMask = '1;
    mFilt = '0; mRxE = '0; mTxA = '0; mTxS = '0;
    mRx = 1'b0; mTx = 1'b0; mStats = 1'b0; mXcvr = 1'b0;
  endtask

  task automatic modelStep(input logic w, input logic [15:0] d, input logic [7:1] e, input logic dn);
    int op;
    logic [10:0] arg;
    logic acc;
    logic [7:1] ev;
    logic [7:0] ack;
    logic ns;
    op  = int'(d[15:11]);
    arg = d[10:0];
    acc = w && !mBusy;
    if (acc && op == 0) begin
      modelReset();
      mBusy = 1'b1; mLop = 2'd0;
      return;
    end
    ev = e;
    if (acc && op == 12) ev[6] = 1'b1;
    ns  = |(ev & mIntMask[7:1]);
    ack = (acc && op == 13) ? arg[7:0] : 8'h00;
    mEvt   = (mEvt & ~ack[7:1]) | ev;
    mLatch = (mLatch & ~ack[0]) | ns;
    if (mBusy && dn) mBusy = 1'b0;
    if (acc) begin
      case (op)
        1:  mWin = arg[2:0];
        2:  begin mXcvr = 1'b1; mBusy = 1'b1; mLop = 2'd1; end
        3:  mRx = 1'b0;
        4:  mRx = 1'b1;
        5:  begin mRx = 1'b0; mBusy = 1'b1; mLop = 2'd2; end
        9:  mTx = 1'b1;
        10: mTx = 1'b0;
        11: begin mTx = 1'b0; mBusy = 1'b1; mLop = 2'd3; end
        14: mIntMask = arg[7:0];
        15: mRdMask = arg[7:0];
        16: mFilt = arg[3:0];
        17: mRxE = arg;
        18: mTxA = arg;
        19: mTxS = arg;
        21: mStats = 1'b1;
        22: mStats = 1'b0;
        23: mXcvr = 1'b0;
        default: ;
      endcase
    end
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s [%s] actual=%0h expected=%0h t=%0t", tag, phase, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R1 window", int'(statusWord[15:13]), int'(mWin));
    check("R1 windowSel", int'(windowSel), int'(mWin));
    check("R3 R5 event bits", int'(statusWord[7:1]), int'(mEvt & mRdMask[7:1]));
    check("R4 R5 latch bit", int'(statusWord[0]), int'(mLatch & mRdMask[0]));
    check("R4 irq", int'(irq), int'(mLatch));
    check("R6 zero bits", int'(statusWord[11:8]), 0);
    check("R6 busy bit", int'(statusWord[12]), int'(mBusy));
    check("R9 cmdBusy", int'(cmdBusy), int'(mBusy));
    if (mBusy) check("R9 longOp", int'(longOp), int'(mLop));
    check("R7 rxEnable", int'(rxEnable), int'(mRx));
    check("R7 txEnable", int'(txEnable), int'(mTx));
    check("R8 rxFilter", int'(rxFilter), int'(mFilt));
    check("R8 rxEarly", int'(rxEarlyThresh), int'(mRxE));
    check("R8 txAvail", int'(txAvailThresh), int'(mTxA));
    check("R8 txStart", int'(txStartThresh), int'(mTxS));
    check("R11 stats", int'(statsEnable), int'(mStats));
    check("R11 xcvr", int'(xcvrEnable), int'(mXcvr));
  endtask

  task automatic tick(input logic w, input logic [15:0] d, input logic [7:1] e, input logic dn);
    cmdWr = w; cmdData = d; evtPulse = e; opDone = dn;
    @(negedge clk);
    modelStep(w, d, e, dn);
    compareAll();
  endtask

  task automatic cmd(input int op, input int arg);
    tick(1'b1, word(op, arg), 7'h00, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 16'h0000, 7'h00, 1'b0);
  endtask

  task automatic done();
    tick(1'b0, 16'h0000, 7'h00, 1'b1);
  endtask

  bit finished = 1'b0;

  initial begin
    int unused;
    unused = $urandom(32'h5eed_c0de);
    modelReset(); mBusy = 1'b0; mLop = 2'd0;
    repeat (3) @(negedge clk);
    compareAll();
    rstN = 1'b1;
    idle(2);

    phase = "R1";
    cmd(1, 5); cmd(1, 11'h7FA); cmd(1, 7); idle(1);

    phase = "R8";
    cmd(16, 11'h7F5); cmd(17, 11'h7FF); cmd(18, 11'h123); cmd(19, 11'h400);
    cmd(4, 0); cmd(9, 11'h7FF); cmd(21, 0); cmd(3, 0); cmd(10, 0); cmd(22, 0); idle(1);

    phase = "R2";
    cmd(14, 8'hFE);
    tick(1'b0, 16'h0, 7'h7F, 1'b0);
    idle(1);
    cmd(13, 8'h0A);
    tick(1'b1, word(13, 8'h14), 7'h02, 1'b0);
    cmd(12, 0);
    cmd(13, 8'hFF); idle(1);

    phase = "R4";
    cmd(14, 8'h04);
    tick(1'b0, 16'h0, 7'h01, 1'b0);
    idle(1);
    tick(1'b0, 16'h0, 7'h02, 1'b0);
    idle(1);
    cmd(13, 8'h04); idle(1);
    cmd(13, 8'h01); idle(1);

    phase = "R5";
    cmd(15, 8'h0F);
    tick(1'b0, 16'h0, 7'h7F, 1'b0);
    idle(1);
    cmd(15, 8'hFF); idle(1);
    cmd(13, 8'hFF);

    phase = "R12";
    foreach (unused_ops[k]) cmd(unused_ops[k], $urandom_range(0, 2047));
    idle(1);

    phase = "R9";
    tick(1'b0, 16'h0, 7'h00, 1'b1);
    cmd(2, 0); cmd(1, 3); cmd(4, 0); cmd(16, 4'hF); cmd(2, 0); idle(2); done(); idle(1);
    cmd(5, 0); cmd(11, 0); done(); cmd(11, 0); idle(1); done(); done();

    phase = "R10";
    cmd(1, 6); cmd(4, 0); cmd(9, 0); cmd(14, 8'hFF); cmd(15, 8'h00); cmd(17, 11'h55);
    tick(1'b1, word(0, 11'h7FF), 7'h7F, 1'b0);
    idle(1); done(); idle(1);

    phase = "R11";
    cmd(2, 0); done(); cmd(23, 0); cmd(4, 0); cmd(5, 0); done(); cmd(9, 0); cmd(11, 0); done();

    phase = "random";
    for (int i = 0; i < 4000; i++) begin
      logic w, dn;
      logic [7:1] e;
      int op;
      w  = ($urandom_range(0, 9) < 6);
      op = $urandom_range(0, 31);
      if (op == 0 && $urandom_range(0, 3) != 0) op = 13;
      e  = ($urandom_range(0, 9) == 0) ? 7'($urandom_range(0, 127)) : 7'h00;
      dn = mBusy ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 19) == 0);
      tick(w, word(op, $urandom_range(0, 2047)), e, dn);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int unused_ops[12] = '{6, 7, 8, 20, 24, 25, 26, 27, 28, 29, 30, 31};

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule